// File: doc/BRIEF.md
# Burst Packet Transmit Framer

This block builds one outgoing radio burst from a fixed-size payload buffer and shifts it out one bit per serial-clock strobe. The host raises the mode input, writes payload bytes through a byte port until the buffer holds exactly the configured number of bytes, and then gives three throw-away strobes. When the mode input falls, the framer starts the burst: a run of alternating-bit preamble bytes, the destination address, an optional sender address, the payload, and an optional 16-bit check value. Payload and check value can optionally be whitened for DC balance.

The serial data output changes only when a strobe arrives. When the last bit has been strobed, the busy flag drops and the done interrupt rises. The interrupt stays high until the mode input changes level. If the mode input falls before the buffer is full and the three throw-away strobes have arrived, nothing is sent and the buffer is emptied.

Top module: `tx_burst_framer`

## Requirements
- R1: The payload holds `cfg_pay_len + 1` bytes (1 to 32). Writes that arrive after the buffer is full are dropped. A length field of 0 sends exactly one payload byte.
- R2: A burst starts only on a falling edge of `tx_mode` while the buffer is full and at least three `sclk_stb` pulses have been seen with `tx_mode` high after it filled. Any other falling edge sends nothing and empties the buffer.
- R3: The frame order is preamble, destination, sender, payload, check value. Every byte is sent most significant bit first. The preamble is `cfg_pre_len + 1` bytes of 0xAA. The address length is `min(cfg_addr_len, 4) + 1` bytes, and address byte k is bits [8k+7:8k] of the address input, with k = 0 sent first.
- R4: The sender address field, with the same length as the destination field and taken from `cfg_src_addr`, is present only when `cfg_sender_en` is 1.
- R5: When `cfg_crc_en` is 1, a 16-bit check value follows the payload, high byte first. It uses generator 0x1021 and start value 0xFFFF, and covers the unwhitened destination, sender and payload bits. When `cfg_crc_en` is 0, nothing follows the payload.
- R6: When `cfg_scr_en` is 1, each payload and check-value bit is XORed with a key bit from a 7-bit register s that is set to all ones at burst start. The key is s[6]^s[3], and s then shifts left taking the key in at bit 0. Preamble and address bits are never whitened.
- R7: Exactly one frame bit advances per `sclk_stb`. `busy` is high from the cycle after the start edge until the last bit is strobed. `tx_bit` is 0 whenever `busy` is low. The first bit of every burst is 1.
- R8: `done_irq` rises in the same cycle that `busy` falls at the end of a burst, and clears on the next level change of `tx_mode`. After reset, `busy`, `tx_bit` and `done_irq` are 0.
- R9: Byte writes while `tx_mode` is low or while a burst is in flight have no effect on the payload sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pay_len | input | 5 | Payload byte count minus one |
| cfg_addr_len | input | 3 | Address byte count minus one (capped at 4) |
| cfg_pre_len | input | 2 | Preamble byte count minus one |
| cfg_sender_en | input | 1 | Include the sender address field |
| cfg_crc_en | input | 1 | Append the 16-bit check value |
| cfg_scr_en | input | 1 | Whiten payload and check value |
| cfg_dst_addr | input | 40 | Destination address bytes |
| cfg_src_addr | input | 40 | Sender address bytes |
| wr_en | input | 1 | Payload byte write strobe |
| wr_data | input | 8 | Payload byte |
| sclk_stb | input | 1 | Serial clock strobe, one per bit |
| tx_mode | input | 1 | Load (high) / transmit start on fall |
| tx_bit | output | 1 | Serial frame bit |
| done_irq | output | 1 | Burst complete interrupt |
| busy | output | 1 | Burst in progress |

## Verification
The hardest case to reach is a falling mode edge that arrives with the buffer partly loaded, or loaded but short of the three throw-away strobes. Only the content of the next good burst can show whether the stale bytes were really discarded. The stimulus aborts both ways, then loads a fresh payload and compares every frame bit. The stimulus also writes stray bytes while the mode is low, while the buffer is full, and between strobes of a burst in flight. It varies the strobe spacing so that the bit stepping is separated from the clock.

// File: rtl/tx_framer_pkg.sv
package tx_framer_pkg;

   typedef enum logic [2:0] {
      SEG_PRE = 3'd0,
      SEG_DST = 3'd1,
      SEG_SND = 3'd2,
      SEG_PAY = 3'd3,
      SEG_CHK = 3'd4
   } seg_e;

   localparam logic [7:0]  PREAMBLE_BYTE = 8'hAA;
   localparam logic [15:0] CHK_POLY      = 16'h1021;
   localparam logic [15:0] CHK_INIT      = 16'hFFFF;
   localparam int          DUMMY_STROBES = 3;

endpackage

// File: rtl/tx_payload_buf.sv
module tx_payload_buf #(
   parameter int DEPTH = 32,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] len_field,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   output logic             full
);

   localparam int FILL_W = IDX_W + 1;

   if (DEPTH != (1 << IDX_W)) begin : g_bad_depth
      $error("tx_payload_buf: DEPTH must be a power of two matching IDX_W");
   end

   logic [FILL_W-1:0] fill_q;
   logic [FILL_W-1:0] need;
   logic              accept;
   logic [7:0]        mem [DEPTH];

   assign need    = {1'b0, len_field} + FILL_W'(1);
   assign full    = (fill_q == need);
   assign accept  = wr_en && !full;
   assign rd_data = mem[rd_idx];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (accept && (fill_q[IDX_W-1:0] == IDX_W'(g))) mem[g] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fill_q <= '0;
      else if (clear)  fill_q <= '0;
      else if (accept) fill_q <= fill_q + FILL_W'(1);
   end

   // R1: a full buffer never advances its fill count
   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clear) |=> (fill_q == $past(fill_q)));

endmodule

// File: rtl/tx_chk16.sv
module tx_chk16 #(
   parameter logic [15:0] POLY = 16'h1021,
   parameter logic [15:0] INIT = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        shift_en,
   input  logic        din,
   output logic [15:0] value
);

   logic fb;
   assign fb = value[15] ^ din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        value <= INIT;
      else if (init)     value <= INIT;
      else if (shift_en) value <= {value[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
   end

   // R5: restart and accumulation never coincide
   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(init && shift_en));

endmodule

// File: rtl/tx_whitener.sv
module tx_whitener #(
   parameter int STAGES = 7,
   parameter int TAP    = 4,
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seed,
   input  logic step,
   output logic key
);

   if (TAP < 1 || TAP >= STAGES) begin : g_bad_tap
      $error("tx_whitener: TAP must lie inside the register");
   end

   if (ENABLE) begin : g_lfsr
      logic [STAGES-1:0] s_q;
      assign key = s_q[STAGES-1] ^ s_q[TAP-1];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    s_q <= '1;
         else if (seed) s_q <= '1;
         else if (step) s_q <= {s_q[STAGES-2:0], key};
      end
      // R6: the whitening register never locks up at zero
      a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
         s_q != '0);
   end else begin : g_none
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, seed, step};
      assign key = 1'b0;
   end

endmodule

// File: rtl/tx_burst_framer.sv
module tx_burst_framer
   import tx_framer_pkg::*;
#(
   parameter int MAX_PAYLOAD  = 32,
   parameter int ADDR_MAX     = 5,
   parameter int PRE_W        = 2,
   parameter bit HAS_WHITENER = 1'b1,
   localparam int LEN_W  = $clog2(MAX_PAYLOAD),
   localparam int AF_W   = $clog2(ADDR_MAX),
   localparam int ADDR_W = 8 * ADDR_MAX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  cfg_pay_len,
   input  logic [AF_W-1:0]   cfg_addr_len,
   input  logic [PRE_W-1:0]  cfg_pre_len,
   input  logic              cfg_sender_en,
   input  logic              cfg_crc_en,
   input  logic              cfg_scr_en,
   input  logic [ADDR_W-1:0] cfg_dst_addr,
   input  logic [ADDR_W-1:0] cfg_src_addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              sclk_stb,
   input  logic              tx_mode,
   output logic              tx_bit,
   output logic              done_irq,
   output logic              busy
);

   localparam int CNT_W = LEN_W;

   if (MAX_PAYLOAD != (1 << LEN_W)) begin : g_bad_payload
      $error("tx_burst_framer: MAX_PAYLOAD must be a power of two");
   end
   if (ADDR_MAX < 2 || ADDR_MAX > MAX_PAYLOAD) begin : g_bad_addr
      $error("tx_burst_framer: ADDR_MAX out of range");
   end
   if ((1 << PRE_W) > MAX_PAYLOAD) begin : g_bad_pre
      $error("tx_burst_framer: preamble counter too wide");
   end

   function automatic logic [7:0] pick_byte(input logic [ADDR_W-1:0] v,
                                            input logic [CNT_W-1:0]  i);
      logic [7:0] r;
      r = '0;
      for (int k = 0; k < ADDR_MAX; k++) begin
         if (i == CNT_W'(k)) r = v[8*k +: 8];
      end
      return r;
   endfunction

   seg_e             seg_q, seg_nxt;
   logic [CNT_W-1:0] byte_q, seg_last, addr_last;
   logic [2:0]       bit_q;
   logic             busy_q, done_q, mode_q;
   logic [1:0]       dummy_q;
   logic             mode_chg, mode_fall, start, adv, finish, seg_final;
   logic             buf_full, buf_clear, buf_we;
   logic [7:0]       buf_rd, cur_byte;
   logic [15:0]      chk_val;
   logic             raw_bit, key, in_white, in_chk_span;

   assign mode_chg  = tx_mode ^ mode_q;
   assign mode_fall = mode_q && !tx_mode;
   assign start     = !busy_q && mode_fall && buf_full && (dummy_q == 2'(DUMMY_STROBES));
   assign adv       = busy_q && sclk_stb;
   assign buf_we    = wr_en && tx_mode && !busy_q;

   assign addr_last = (cfg_addr_len >= AF_W'(ADDR_MAX - 1)) ? CNT_W'(ADDR_MAX - 1)
                                                             : CNT_W'(cfg_addr_len);

   always_comb begin
      seg_nxt   = seg_q;
      seg_final = 1'b0;
      seg_last  = '0;
      cur_byte  = PREAMBLE_BYTE;
      unique case (seg_q)
         SEG_PRE: begin
            seg_last = CNT_W'(cfg_pre_len);
            seg_nxt  = SEG_DST;
         end
         SEG_DST: begin
            seg_last = addr_last;
            cur_byte = pick_byte(cfg_dst_addr, byte_q);
            seg_nxt  = cfg_sender_en ? SEG_SND : SEG_PAY;
         end
         SEG_SND: begin
            seg_last = addr_last;
            cur_byte = pick_byte(cfg_src_addr, byte_q);
            seg_nxt  = SEG_PAY;
         end
         SEG_PAY: begin
            seg_last  = cfg_pay_len;
            cur_byte  = buf_rd;
            seg_nxt   = SEG_CHK;
            seg_final = !cfg_crc_en;
         end
         SEG_CHK: begin
            seg_last  = CNT_W'(1);
            cur_byte  = (byte_q == '0) ? chk_val[15:8] : chk_val[7:0];
            seg_final = 1'b1;
         end
         default: ;
      endcase
   end

   assign raw_bit     = cur_byte[3'd7 - bit_q];
   assign in_white    = (seg_q == SEG_PAY) || (seg_q == SEG_CHK);
   assign in_chk_span = (seg_q == SEG_DST) || (seg_q == SEG_SND) || (seg_q == SEG_PAY);
   assign finish      = adv && (bit_q == 3'd7) && (byte_q == seg_last) && seg_final;
   assign buf_clear   = finish || (mode_fall && !start && !busy_q);

   assign tx_bit   = busy_q && (raw_bit ^ (cfg_scr_en && in_white && key));
   assign busy     = busy_q;
   assign done_irq = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q   <= SEG_PRE;
         byte_q  <= '0;
         bit_q   <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         mode_q  <= 1'b0;
         dummy_q <= '0;
      end else begin
         mode_q <= tx_mode;
         if (mode_chg) done_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            seg_q  <= SEG_PRE;
            byte_q <= '0;
            bit_q  <= '0;
         end else if (adv) begin
            if (bit_q != 3'd7) begin
               bit_q <= bit_q + 3'd1;
            end else begin
               bit_q <= '0;
               if (byte_q != seg_last) begin
                  byte_q <= byte_q + CNT_W'(1);
               end else begin
                  byte_q <= '0;
                  if (seg_final) begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     seg_q <= seg_nxt;
                  end
               end
            end
         end
         if (buf_clear || start)
            dummy_q <= '0;
         else if (!busy_q && tx_mode && buf_full && sclk_stb && dummy_q != 2'(DUMMY_STROBES))
            dummy_q <= dummy_q + 2'd1;
      end
   end

   tx_payload_buf #(.DEPTH(MAX_PAYLOAD), .IDX_W(LEN_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clear(buf_clear), .wr_en(buf_we), .wr_data(wr_data),
      .len_field(cfg_pay_len), .rd_idx(byte_q), .rd_data(buf_rd), .full(buf_full)
   );

   tx_chk16 #(.POLY(CHK_POLY), .INIT(CHK_INIT)) u_chk (
      .clk(clk), .rst_n(rst_n), .init(start), .shift_en(adv && in_chk_span),
      .din(raw_bit), .value(chk_val)
   );

   tx_whitener #(.STAGES(7), .TAP(4), .ENABLE(HAS_WHITENER)) u_white (
      .clk(clk), .rst_n(rst_n), .seed(start), .step(adv && in_white), .key(key)
   );

   // R2: a burst only begins from a full buffer
   a_r2_start_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(buf_full));
   // R7: first bit of every burst is a preamble one
   a_r7_first_bit_one: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> tx_bit);
   // R7: line is quiet when idle
   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !tx_bit);
   // R8: completion raises the interrupt
   a_r8_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);
   // R8: interrupt never overlaps a burst in flight
   a_r8_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !done_q);

endmodule

// File: tb/tx_burst_framer_tb.sv
module tx_burst_framer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cfg_pay_len = '0;
   logic [2:0]  cfg_addr_len = '0;
   logic [1:0]  cfg_pre_len = '0;
   logic        cfg_sender_en = 1'b0, cfg_crc_en = 1'b0, cfg_scr_en = 1'b0;
   logic [39:0] cfg_dst_addr = 40'h11_22_33_44_55;
   logic [39:0] cfg_src_addr = 40'hA5_3C_96_0F_E1;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        sclk_stb = 1'b0, tx_mode = 1'b0;
   logic        tx_bit, done_irq, busy;

   always #4 clk = ~clk;

   tx_burst_framer u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_pay_len(cfg_pay_len), .cfg_addr_len(cfg_addr_len),
      .cfg_pre_len(cfg_pre_len), .cfg_sender_en(cfg_sender_en), .cfg_crc_en(cfg_crc_en),
      .cfg_scr_en(cfg_scr_en), .cfg_dst_addr(cfg_dst_addr), .cfg_src_addr(cfg_src_addr),
      .wr_en(wr_en), .wr_data(wr_data), .sclk_stb(sclk_stb), .tx_mode(tx_mode),
      .tx_bit(tx_bit), .done_irq(done_irq), .busy(busy)
   );

   int    checks = 0, failures = 0, cyc = 0;
   string cur_req = "R3";

   // reference model state
   int        fill_m = 0, dummy_m = 0, idx_m = 0;
   bit        busy_m = 0, done_m = 0, mode_prev_m = 0;
   bit [7:0]  fifo_m [32];
   bit        frame [$];
   bit [15:0] chk_m;
   bit [6:0]  sr_m;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic push_byte(input bit [7:0] b, input bit accum, input bit white);
      for (int i = 7; i >= 0; i--) begin
         bit r, k;
         r = b[i];
         if (accum) begin
            bit f;
            f = chk_m[15] ^ r;
            chk_m = {chk_m[14:0], 1'b0};
            if (f) chk_m = chk_m ^ 16'h1021;
         end
         if (white && cfg_scr_en) begin
            k = sr_m[6] ^ sr_m[3];
            sr_m = {sr_m[5:0], k};
            r = r ^ k;
         end
         frame.push_back(r);
      end
   endtask

   task automatic build_frame();
      int na;
      bit [15:0] fin;
      frame.delete();
      chk_m = 16'hFFFF;
      sr_m  = 7'h7F;
      na = (int'(cfg_addr_len) > 4) ? 5 : int'(cfg_addr_len) + 1;
      for (int i = 0; i <= int'(cfg_pre_len); i++) push_byte(8'hAA, 0, 0);
      for (int i = 0; i < na; i++) push_byte(cfg_dst_addr[8*i +: 8], 1, 0);
      if (cfg_sender_en)
         for (int i = 0; i < na; i++) push_byte(cfg_src_addr[8*i +: 8], 1, 0);
      for (int i = 0; i <= int'(cfg_pay_len); i++) push_byte(fifo_m[i], 1, 1);
      if (cfg_crc_en) begin
         fin = chk_m;
         push_byte(fin[15:8], 0, 1);
         push_byte(fin[7:0], 0, 1);
      end
   endtask

   always @(posedge clk) begin
      bit fin;
      int need;
      fin  = 0;
      need = int'(cfg_pay_len) + 1;
      cyc++;
      if (!rst_n) begin
         fill_m = 0; dummy_m = 0; idx_m = 0;
         busy_m = 0; done_m = 0; mode_prev_m = 0;
      end else begin
         if (busy_m) begin
            if (sclk_stb) begin
               idx_m++;
               if (idx_m == frame.size()) begin
                  busy_m = 0; fin = 1; fill_m = 0; dummy_m = 0;
               end
            end
         end else if (mode_prev_m && !tx_mode) begin
            if (fill_m == need && dummy_m == 3) begin
               build_frame();
               busy_m = 1; idx_m = 0;
            end else begin
               fill_m = 0; dummy_m = 0;
            end
         end else if (tx_mode) begin
            if (sclk_stb && fill_m == need && dummy_m < 3) dummy_m++;
            if (wr_en && fill_m < need) begin
               fifo_m[fill_m] = wr_data;
               fill_m++;
            end
         end
         if (tx_mode != mode_prev_m) done_m = 0;
         if (fin) done_m = 1;
         mode_prev_m = tx_mode;
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit eb;
         eb = busy_m ? frame[idx_m] : 1'b0;
         chk(busy === busy_m, "R7", "busy", int'(busy), int'(busy_m));
         chk(tx_bit === eb, cur_req, "tx_bit", int'(tx_bit), int'(eb));
         chk(done_irq === done_m, "R8", "done_irq", int'(done_irq), int'(done_m));
      end
   end

   task automatic load(input int nwr, input int base, input int ndummy);
      tx_mode = 1'b1;
      @(negedge clk);
      for (int i = 0; i < nwr; i++) begin
         wr_en = 1'b1;
         wr_data = 8'(i * 29 + base);
         @(negedge clk);
      end
      wr_en = 1'b0;
      for (int i = 0; i < ndummy; i++) begin
         sclk_stb = 1'b1;
         @(negedge clk);
      end
      sclk_stb = 1'b0;
      tx_mode = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_pkt(input int nwr, input int base, input int gap, input bit stray);
      int k;
      load(nwr, base, 3);
      k = 0;
      while (busy_m) begin
         sclk_stb = ((k % (gap + 1)) == 0);
         wr_en    = stray;
         wr_data  = 8'hEE;
         k++;
         @(negedge clk);
      end
      sclk_stb = 1'b0;
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         if (cyc >= 150000) begin
            failures++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(busy === 1'b0, "R8", "reset busy", int'(busy), 0);
      chk(tx_bit === 1'b0, "R8", "reset tx_bit", int'(tx_bit), 0);
      chk(done_irq === 1'b0, "R8", "reset done_irq", int'(done_irq), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: minimal frame, every-cycle strobes
      cur_req = "R3";
      cfg_pay_len = 5'd3; cfg_addr_len = 3'd0; cfg_pre_len = 2'd0;
      send_pkt(4, 7, 0, 0);
      chk(done_irq === 1'b1, "R8", "done after burst", int'(done_irq), 1);

      // R8: mode change clears the interrupt
      tx_mode = 1'b1;
      @(negedge clk);
      chk(done_irq === 1'b0, "R8", "done cleared on mode rise", int'(done_irq), 0);
      tx_mode = 1'b0;
      @(negedge clk);

      // R4 and R5: sender field and check value, sparse strobes
      cur_req = "R4";
      cfg_pay_len = 5'd5; cfg_addr_len = 3'd2; cfg_pre_len = 2'd2;
      cfg_sender_en = 1'b1; cfg_crc_en = 1'b1;
      send_pkt(6, 91, 1, 0);
      cur_req = "R5";
      cfg_sender_en = 1'b0;
      send_pkt(6, 13, 0, 0);

      // R6: whitening over full 32-byte payload and check value, capped address
      cur_req = "R6";
      cfg_pay_len = 5'd31; cfg_addr_len = 3'd7; cfg_pre_len = 2'd1; cfg_scr_en = 1'b1;
      send_pkt(32, 200, 2, 0);

      // R1: one-byte payload, surplus writes dropped
      cur_req = "R1";
      cfg_pay_len = 5'd0; cfg_addr_len = 3'd1;
      send_pkt(4, 55, 0, 0);

      // R2: abort with partial load, then with only two throw-away strobes
      cur_req = "R2";
      cfg_pay_len = 5'd3; cfg_scr_en = 1'b0; cfg_crc_en = 1'b1;
      load(2, 99, 3);
      repeat (4) @(negedge clk);
      chk(busy === 1'b0, "R2", "no burst on partial load", int'(busy), 0);
      load(4, 120, 2);
      repeat (4) @(negedge clk);
      chk(busy === 1'b0, "R2", "no burst on short dummies", int'(busy), 0);
      send_pkt(4, 3, 0, 0);

      // R9: writes while mode low, and stray writes during the burst
      cur_req = "R9";
      wr_en = 1'b1; wr_data = 8'h5A;
      repeat (3) @(negedge clk);
      wr_en = 1'b0;
      cfg_sender_en = 1'b1;
      send_pkt(4, 61, 1, 1);
      send_pkt(4, 17, 0, 0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule